// File: doc/BRIEF.md
# Chainable FIFO Slice with Depth-Expansion Tokens

This block is one slice of a first-in/first-out buffer that can either run on its own or be linked in a ring with identical slices to form one deeper buffer. Each slice holds its own storage, a write pointer, a read pointer and an occupancy count. Ownership is tracked by two tokens, one for writing and one for reading. Write and read strobes are shared by every slice in the ring, but only the slice holding the matching token acts on them.

When the token holder writes or reads its last storage location, it raises a one-cycle pulse on the matching token output and gives up that token. The next slice in the ring takes the token on the same clock edge and restarts the matching pointer at location zero. Exactly one slice has its first-load input driven low, and that slice holds both tokens after reset. With chain mode off, the slice holds both tokens all the time and its pointers simply wrap. In that mode the write-token output carries a half-full indication instead of pulses.

The ring-level empty flag is the OR of every slice's empty output, and the ring-level full flag is the OR of every slice's full output. Read data from the slices is merged using each slice's read-valid output.

Top module: `fifo_xp_slice`

## Requirements
- R1: After reset in chain mode, the slice with `first_load_n` low holds both tokens and every other slice holds neither. Both token outputs are low, no slice reports full, and only the first-load slice reports empty.
- R2: With `chain_mode` low, the slice always holds both tokens, stores up to DEPTH words, and its pointers wrap from DEPTH-1 back to 0.
- R3: With `chain_mode` low, `xo_wr_hf` is high exactly when the occupancy is greater than DEPTH/2, updated one edge after the strobe.
- R4: A write is accepted only when `wr_en` is high, the slice holds the write token and the slice is not full. In every other case the write has no effect, and a write offered while full is never read back.
- R5: A read is accepted only when `rd_en` is high, the slice holds the read token and the slice is not empty. An accepted read returns its word on `rd_data` with `rd_valid` high one edge later. Otherwise `rd_valid` stays low.
- R6: In chain mode, `xo_wr_hf` is high during the cycle in which a write to location DEPTH-1 is accepted, and only in that cycle. The slice no longer holds the write token after that edge.
- R7: In chain mode, `xo_rd` is high during the cycle in which a read from location DEPTH-1 is accepted, and only in that cycle. The slice no longer holds the read token after that edge.
- R8: A high level on `xi_wr` or `xi_rd` at a clock edge gives the slice that token. The matching pointer restarts at location 0, so the token wraps around the ring.
- R9: `full` is high when the slice holds the write token and holds DEPTH words. `empty` is high when the slice holds the read token and holds no words. ORed across the ring, these flags give the ring's full and empty state.
- R10: Words written to a ring of slices are read back in the order they were written, across slice boundaries and across ring wrap-around.
- R11: With `chain_mode` low, `xo_rd` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_mode | input | 1 | 1: part of a ring of slices; 0: stand-alone slice |
| first_load_n | input | 1 | Low on the one slice that holds both tokens after reset |
| xi_wr | input | 1 | Write-token pulse from the previous slice |
| xi_rd | input | 1 | Read-token pulse from the previous slice |
| xo_wr_hf | output | 1 | Write-token pulse to the next slice (chain); half-full flag (stand-alone) |
| xo_rd | output | 1 | Read-token pulse to the next slice |
| wr_en | input | 1 | Write strobe, shared by the ring |
| wr_data | input | WIDTH | Write word |
| rd_en | input | 1 | Read strobe, shared by the ring |
| rd_data | output | WIDTH | Read word, registered |
| rd_valid | output | 1 | `rd_data` holds a word read at the previous edge |
| full | output | 1 | Slice holds the write token and is full |
| empty | output | 1 | Slice holds the read token and is empty |

## Verification
Token outputs are combinational on the cycle of the accepted strobe. The bench drives each strobe just after a falling edge and samples the token outputs one time step later, before the rising edge that commits the access. Flags, the half-full indication and `rd_data`/`rd_valid` change on the rising edge after the strobe, so they are sampled at the following falling edge, after the strobe has been removed. The bench compares the merged read data against a queue model of the ring. Ignored strobes are proved by the value of the next word read out and by the unchanged flags.

// File: rtl/fifo_xp_pkg.sv
// Package: width helpers shared by the chainable FIFO slice and its checker.
// Assumes DEPTH >= 1.
package fifo_xp_pkg;

    // Pointer width for a given depth (at least one bit).
    function automatic int ptr_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

    // Occupancy counter width able to hold 0..depth.
    function automatic int cnt_width(input int depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/xp_token_ctrl.sv
// Module: xp_token_ctrl
// Owns one token (write or read) and the pointer it advances. It accepts a
// strobe only while holding the token and while room allows. In chain mode it
// releases the token with a pulse when location DEPTH-1 is used, and it takes
// the token back (pointer to 0) on an incoming pulse. In stand-alone mode the
// token is always held.
// Assumes at most one slice in the ring holds the token at a time.
module xp_token_ctrl #(
    parameter int DEPTH = 4,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chain_mode,
    input  logic             first_n,
    input  logic             strobe,
    input  logic             room,
    input  logic             tok_in,
    output logic             own,
    output logic [PTR_W-1:0] ptr,
    output logic             fire,
    output logic             tok_out
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic at_last;

    // Access acceptance and token hand-off decode.
    always_comb begin
        at_last = (ptr == LAST);
        fire    = strobe && own && room;
        tok_out = chain_mode && fire && at_last;
    end

    // Pointer advance and token ownership.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own <= !chain_mode || !first_n;
            ptr <= '0;
        end else begin
            if (fire) begin
                ptr <= at_last ? '0 : ptr + PTR_W'(1);
            end
            if (tok_out) begin
                own <= 1'b0;
            end
            if (!chain_mode) begin
                own <= 1'b1;
            end else if (tok_in) begin
                own <= 1'b1;
                ptr <= '0;
            end
        end
    end

endmodule

// File: rtl/xp_occupancy.sv
// Module: xp_occupancy
// Tracks how many words a slice holds and decodes full, empty and above-half.
// Assumes inc is never set while full and dec never set while empty.
module xp_occupancy #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt,
    output logic             is_full,
    output logic             is_empty,
    output logic             above_half
);

    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(DEPTH / 2);

    // Occupancy counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Level decodes.
    always_comb begin
        is_full    = (cnt == CAP);
        is_empty   = (cnt == '0);
        above_half = (cnt > HALF);
    end

endmodule

// File: rtl/xp_slice_mem.sv
// Module: xp_slice_mem
// Storage of one slice: one write port, one registered read port.
// Assumes the caller never reads and writes the same word in one cycle
// unless the read is meant to see the old content.
module xp_slice_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    parameter int PTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [PTR_W-1:0] raddr,
    output logic [WIDTH-1:0] rdata,
    output logic             rvalid
);

    logic [WIDTH-1:0] store [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Registered read port with valid marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= re;
            if (re) begin
                rdata <= store[raddr];
            end
        end
    end

endmodule

// File: rtl/fifo_xp_slice.sv
// Module: fifo_xp_slice (top)
// One FIFO slice that runs stand-alone or as one member of a ring of
// identical slices. Separate write and read tokens circulate through the
// xi_*/xo_* pulses. Strobes are shared across the ring; only the token
// holder acts. In stand-alone mode xo_wr_hf reports above-half occupancy.
// Assumes exactly one slice in a ring has first_load_n low and that
// chain_mode is static after reset.
module fifo_xp_slice #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chain_mode,
    input  logic             first_load_n,
    input  logic             xi_wr,
    input  logic             xi_rd,
    output logic             xo_wr_hf,
    output logic             xo_rd,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid,
    output logic             full,
    output logic             empty
);

    import fifo_xp_pkg::*;

    localparam int PTR_W = ptr_width(DEPTH);
    localparam int CNT_W = cnt_width(DEPTH);

    logic             own_wr, own_rd;
    logic [PTR_W-1:0] wptr, rptr;
    logic             wr_fire, rd_fire;
    logic             wr_pass, rd_pass;
    logic [CNT_W-1:0] cnt;
    logic             cnt_full, cnt_empty, cnt_above_half;

    xp_token_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) wr_tok_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_mode (chain_mode),
        .first_n    (first_load_n),
        .strobe     (wr_en),
        .room       (!cnt_full),
        .tok_in     (xi_wr),
        .own        (own_wr),
        .ptr        (wptr),
        .fire       (wr_fire),
        .tok_out    (wr_pass)
    );

    xp_token_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) rd_tok_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_mode (chain_mode),
        .first_n    (first_load_n),
        .strobe     (rd_en),
        .room       (!cnt_empty),
        .tok_in     (xi_rd),
        .own        (own_rd),
        .ptr        (rptr),
        .fire       (rd_fire),
        .tok_out    (rd_pass)
    );

    xp_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) occ_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (wr_fire),
        .dec        (rd_fire),
        .cnt        (cnt),
        .is_full    (cnt_full),
        .is_empty   (cnt_empty),
        .above_half (cnt_above_half)
    );

    xp_slice_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) mem_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_fire),
        .waddr  (wptr),
        .wdata  (wr_data),
        .re     (rd_fire),
        .raddr  (rptr),
        .rdata  (rd_data),
        .rvalid (rd_valid)
    );

    // Output muxing of the shared pin and the token-qualified flags.
    always_comb begin
        xo_wr_hf = chain_mode ? wr_pass : cnt_above_half;
        xo_rd    = rd_pass;
        full     = own_wr && cnt_full;
        empty    = own_rd && cnt_empty;
    end

endmodule

// File: rtl/fifo_xp_slice_chk.sv
// Module: fifo_xp_slice_chk
// Property checker for fifo_xp_slice, attached with bind below.
// Assumes chain_mode is static after reset.
module fifo_xp_slice_chk #(
    parameter int DEPTH = 4
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      chain_mode,
    input logic                                      xi_wr,
    input logic                                      xi_rd,
    input logic                                      xo_wr_hf,
    input logic                                      xo_rd,
    input logic                                      wr_en,
    input logic                                      rd_en,
    input logic                                      own_wr,
    input logic                                      own_rd,
    input logic [fifo_xp_pkg::ptr_width(DEPTH)-1:0]  wptr,
    input logic [fifo_xp_pkg::ptr_width(DEPTH)-1:0]  rptr,
    input logic [fifo_xp_pkg::cnt_width(DEPTH)-1:0]  cnt
);

    localparam int CNT_W = fifo_xp_pkg::cnt_width(DEPTH);

    // R4: occupancy never exceeds the capacity.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));

    // R4: without the write token and without reads, occupancy stays put.
    a_r4_no_write_without_token: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_wr && !rd_en) |=> $stable(cnt));

    // R5: without the read token and without writes, occupancy stays put.
    a_r5_no_read_without_token: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_rd && !wr_en) |=> $stable(cnt));

    // R6: write-token pulse lasts one cycle and releases ownership.
    a_r6_wr_pass_release: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && xo_wr_hf && !xi_wr) |=> (!own_wr && !xo_wr_hf));

    // R7: read-token pulse lasts one cycle and releases ownership.
    a_r7_rd_pass_release: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && xo_rd && !xi_rd) |=> (!own_rd && !xo_rd));

    // R8: an incoming write token is taken with the pointer at 0.
    a_r8_take_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && xi_wr) |=> (own_wr && wptr == '0));

    // R8: an incoming read token is taken with the pointer at 0.
    a_r8_take_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_mode && xi_rd) |=> (own_rd && rptr == '0));

    // R2: a stand-alone slice holds both tokens.
    a_r2_single_owns: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_mode |-> (own_wr && own_rd));

    // R11: a stand-alone slice never emits a read-token pulse.
    a_r11_single_no_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_mode |-> !xo_rd);

endmodule

bind fifo_xp_slice fifo_xp_slice_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chain_mode (chain_mode),
    .xi_wr      (xi_wr),
    .xi_rd      (xi_rd),
    .xo_wr_hf   (xo_wr_hf),
    .xo_rd      (xo_rd),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .own_wr     (own_wr),
    .own_rd     (own_rd),
    .wptr       (wptr),
    .rptr       (rptr),
    .cnt        (cnt)
);

// File: tb/fifo_xp_slice_tb_top.sv
module fifo_xp_slice_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int D   = 4;
    localparam int CAP = 3 * D;

    // Table entry: {wr, rd, repeat[5:0], exp_empty, exp_full}
    localparam int NT = 10;
    localparam logic [9:0] TBL [NT] = '{
        {1'b1, 1'b0, 6'd5,  1'b0, 1'b0},
        {1'b0, 1'b1, 6'd2,  1'b0, 1'b0},
        {1'b1, 1'b1, 6'd4,  1'b0, 1'b0},
        {1'b1, 1'b0, 6'd9,  1'b0, 1'b1},
        {1'b1, 1'b0, 6'd2,  1'b0, 1'b1},
        {1'b1, 1'b1, 6'd1,  1'b0, 1'b0},
        {1'b0, 1'b1, 6'd11, 1'b1, 1'b0},
        {1'b0, 1'b1, 6'd2,  1'b1, 1'b0},
        {1'b1, 1'b1, 6'd1,  1'b0, 1'b0},
        {1'b0, 1'b1, 6'd1,  1'b1, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // ring of three slices
    logic         wr_en = 1'b0, rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [2:0]   xw, xr, rv, fl, em;
    logic [W-1:0] rdq [3];

    fifo_xp_slice #(.WIDTH(W), .DEPTH(D)) dut_i (
        .clk(clk), .rst_n(rst_n), .chain_mode(1'b1), .first_load_n(1'b0),
        .xi_wr(xw[2]), .xi_rd(xr[2]), .xo_wr_hf(xw[0]), .xo_rd(xr[0]),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rdq[0]), .rd_valid(rv[0]), .full(fl[0]), .empty(em[0]));

    fifo_xp_slice #(.WIDTH(W), .DEPTH(D)) slice1_i (
        .clk(clk), .rst_n(rst_n), .chain_mode(1'b1), .first_load_n(1'b1),
        .xi_wr(xw[0]), .xi_rd(xr[0]), .xo_wr_hf(xw[1]), .xo_rd(xr[1]),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rdq[1]), .rd_valid(rv[1]), .full(fl[1]), .empty(em[1]));

    fifo_xp_slice #(.WIDTH(W), .DEPTH(D)) slice2_i (
        .clk(clk), .rst_n(rst_n), .chain_mode(1'b1), .first_load_n(1'b1),
        .xi_wr(xw[1]), .xi_rd(xr[1]), .xo_wr_hf(xw[2]), .xo_rd(xr[2]),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rdq[2]), .rd_valid(rv[2]), .full(fl[2]), .empty(em[2]));

    // stand-alone slice
    logic         s_wr = 1'b0, s_rd = 1'b0;
    logic [W-1:0] s_wdata = '0, s_rdata;
    logic         s_hf, s_xo_rd, s_rv, s_full, s_empty;

    fifo_xp_slice #(.WIDTH(W), .DEPTH(D)) sgl_i (
        .clk(clk), .rst_n(rst_n), .chain_mode(1'b0), .first_load_n(1'b1),
        .xi_wr(1'b0), .xi_rd(1'b0), .xo_wr_hf(s_hf), .xo_rd(s_xo_rd),
        .wr_en(s_wr), .wr_data(s_wdata), .rd_en(s_rd),
        .rd_data(s_rdata), .rd_valid(s_rv), .full(s_full), .empty(s_empty));

    logic         ch_valid, ch_empty, ch_full;
    logic [W-1:0] ch_data;
    always_comb begin
        ch_valid = |rv;
        ch_empty = |em;
        ch_full  = |fl;
        ch_data  = (rv[0] ? rdq[0] : '0) | (rv[1] ? rdq[1] : '0) | (rv[2] ? rdq[2] : '0);
    end

    int           q[$];
    int           sq[$];
    logic [W-1:0] next_val = 8'h10;
    logic [2:0]   last_xw, last_xr;
    bit           saw_srd;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One ring cycle; entered and left at a falling edge.
    task automatic op(input logic w, input logic r);
        logic [W-1:0] d;
        bit wok, rok;
        int exp;
        d = next_val;
        wok = w && (q.size() < CAP);
        rok = r && (q.size() > 0);
        exp = 0;
        wr_en = w; rd_en = r; wr_data = d;
        #1;
        last_xw = xw; last_xr = xr;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        if (rok) exp = q.pop_front();
        if (wok) q.push_back(int'(d));
        if (w) next_val = next_val + 8'd1;
        if (r) begin
            check(rok ? "R10 read data order" : "R5 read while empty ignored",
                  rok ? int'(ch_data) : int'(ch_valid), rok ? exp : 0);
            if (rok) check("R5 rd_valid after accepted read", int'(ch_valid), 1);
        end
    endtask

    // One stand-alone cycle.
    task automatic sop(input logic w, input logic r);
        logic [W-1:0] d;
        bit wok, rok;
        int exp;
        d = next_val;
        wok = w && (sq.size() < D);
        rok = r && (sq.size() > 0);
        exp = 0;
        s_wr = w; s_rd = r; s_wdata = d;
        #1;
        if (s_xo_rd) saw_srd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        s_wr = 1'b0; s_rd = 1'b0;
        if (rok) exp = sq.pop_front();
        if (wok) sq.push_back(int'(d));
        if (w) next_val = next_val + 8'd1;
        if (rok) check("R2 stand-alone read data", int'(s_rdata), exp);
        if (r && !rok) check("R5 stand-alone read while empty", int'(s_rv), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 empty flags after reset", int'(em), 3'b001);
        check("R1 full flags after reset", int'(fl), 0);
        check("R1 token outputs after reset", int'({xw, xr}), 0);
        check("R1 rd_valid after reset", int'(ch_valid), 0);
        check("R3 stand-alone half-full after reset", int'(s_hf), 0);

        // R6 write token hand-off
        for (int i = 0; i < 3; i++) op(1'b1, 1'b0);
        check("R6 no pulse before last location", int'(last_xw), 0);
        op(1'b1, 1'b0);
        check("R6 pulse on write to last location", int'(last_xw), 3'b001);
        op(1'b1, 1'b0);
        check("R6 token released, R8 next slice at location 0", int'(last_xw), 0);
        check("R9 empty flags with data in slice0", int'(em), 0);

        // R7 read token hand-off
        for (int i = 0; i < 3; i++) op(1'b0, 1'b1);
        op(1'b0, 1'b1);
        check("R7 pulse on read of last location", int'(last_xr), 3'b001);
        op(1'b0, 1'b1);
        check("R7 read token released", int'(last_xr), 0);
        check("R8 R9 empty now reported by slice1", int'(em), 3'b010);

        // R8 ring wrap: slice2 hands write token back to slice0
        for (int i = 0; i < 7; i++) op(1'b1, 1'b0);
        check("R8 slice2 passes write token to slice0", int'(last_xw), 3'b100);
        for (int i = 0; i < 8; i++) op(1'b0, 1'b1);
        check("R9 ring empty after drain", int'(ch_empty), 1);

        // table of ring vectors
        for (int t = 0; t < NT; t++) begin
            for (int k = 0; k < int'(TBL[t][7:2]); k++) op(TBL[t][9], TBL[t][8]);
            check("R9 ring empty flag (table)", int'(ch_empty), int'(TBL[t][1]));
            check("R4 R9 ring full flag (table)", int'(ch_full), int'(TBL[t][0]));
        end

        // stand-alone slice
        saw_srd = 1'b0;
        sop(1'b1, 1'b0);
        sop(1'b1, 1'b0);
        check("R3 half-full low at DEPTH/2", int'(s_hf), 0);
        sop(1'b1, 1'b0);
        check("R3 half-full high above DEPTH/2", int'(s_hf), 1);
        sop(1'b1, 1'b0);
        check("R2 stand-alone full", int'(s_full), 1);
        sop(1'b1, 1'b0);
        check("R4 write while full ignored", int'(s_full), 1);
        sop(1'b0, 1'b1);
        check("R3 half-full high at three words", int'(s_hf), 1);
        sop(1'b0, 1'b1);
        check("R3 half-full low after read", int'(s_hf), 0);
        sop(1'b0, 1'b1);
        sop(1'b0, 1'b1);
        check("R2 stand-alone empty", int'(s_empty), 1);
        sop(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) sop(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) sop(1'b0, 1'b1);
        check("R2 pointers wrapped, empty again", int'(s_empty), 1);
        check("R11 no read pulse in stand-alone", int'(saw_srd), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule